// File: doc/BRIEF.md
# Off-Page DRAM Write Sequencer

This block runs one complete write cycle to an asynchronous DRAM on a bus where the row being written is not already open. It drives the active-low row strobe, column strobe and write enable. It also drives a multiplexed row/column address and the write data. Every edge is placed on a half bus-clock boundary. To make that possible the block is clocked by a fast clock at twice the bus frequency, so one fast tick equals half a bus clock. In this brief, T stands for one bus clock and a tick for one fast clock.

Three 2-bit wait counts set how long the cycle stretches:

- the precharge wait count `cfg_rp`;
- the row-to-column wait count `cfg_rh`;
- the data-access wait count `cfg_da`.

A sampled external wait input adds further bus clocks to the column strobe. A requester raises `req` for one tick while the block is idle. It gives a full address, write data and the wait counts with that request. The block answers with a one-tick `done` at the end of the cycle.

Top module: `dram_wr_seq`

## Requirements
- R1: Measured from the first tick with `we_n` low to the first tick with `ras_n` high again, a cycle lasts 6 + 2·(rp + rh + da + w) ticks. Here w is the number of sampled waits.
- R2: After a request is accepted, `ras_n` stays high and `mem_addr` carries the row for 1 + 2·rp ticks before `ras_n` falls. The row is bits [2·MA_W-1:MA_W] of `req_addr`.
- R3: The row stays on `mem_addr` for 1 + 2·rh ticks after `ras_n` falls. Then `mem_addr` switches to the column, which is bits [MA_W-1:0] of `req_addr`.
- R4: `cas_n` falls 2 + 2·rh ticks after `ras_n` falls, and `cas_n` is never low while `ras_n` is high.
- R5: The column is on `mem_addr` exactly 1 tick before `cas_n` falls.
- R6: `cas_n` stays low for 2 + 2·da + 2·w ticks. `ext_wait` is sampled once per bus clock, at the fast edge that ends tick 1 + 2·da + 2·j of the column-strobe phase (j = 0, 1, …, counting the first low tick as 0). Each high sample adds 2 ticks. At all other times `ext_wait` has no effect.
- R7: `ras_n` stays low for 5 + 2·rh + 2·da + 2·w ticks in total, so it rises 1 tick after `cas_n`.
- R8: `we_n` is low and the write data is driven from the first tick of the cycle. That is at least 2 + 2·rp + 2·rh ticks before `cas_n` falls. `we_n` is low whenever `cas_n` is low.
- R9: `mem_wdata` holds the accepted data, and `mem_addr` shows only the accepted row or column, on every tick until `done` inclusive. This holds even if the request inputs change.
- R10: `done` is high for exactly one tick, which is the first tick with `ras_n` back high. `we_n` returns high on the next tick.
- R11: A `req` raised while a cycle is in progress is ignored. No second cycle follows, and the held address and data are unchanged.
- R12: During and after synchronous reset, `ras_n`, `cas_n` and `we_n` are high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Write request, taken only when idle |
| req_addr | input | 2*MA_W | Row (upper half) and column (lower half) |
| req_data | input | DATA_W | Data to write |
| cfg_rp | input | 2 | Precharge wait count |
| cfg_rh | input | 2 | Row-to-column wait count |
| cfg_da | input | 2 | Data-access wait count |
| ext_wait | input | 1 | External wait, active high |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mem_addr | output | MA_W | Multiplexed row/column address |
| mem_wdata | output | DATA_W | Write data |
| done | output | 1 | One-tick end-of-cycle pulse |

## Verification
The bench targets three kinds of error.

- **Wait-count timing.** Every one of the 64 wait-count settings is run with 0 to 3 external waits. Each strobe interval is measured in ticks. An off-by-one in any phase counter shifts one interval and also the total cycle length.
- **Wait-input sampling.** `ext_wait` is held high outside the column-strobe window and up to the last sample that should count. A design that sampled it at the wrong tick, or in another phase, would add the wrong number of bus clocks.
- **Hold and re-request.** Data and address are watched every tick, and a second request is injected mid-cycle. A design that re-latched its inputs while busy would change `mem_wdata` or start a second cycle after `done`.

// File: rtl/dram_wr_pkg.sv
package dram_wr_pkg;

    localparam int WAIT_W = 2;
    localparam int CNT_W  = WAIT_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_TAIL,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [WAIT_W-1:0] rp;
        logic [WAIT_W-1:0] rh;
        logic [WAIT_W-1:0] da;
    } wait_cfg_t;

    // Phase that follows a given phase once its tick budget is used.
    function automatic seq_state_e next_phase(seq_state_e st);
        case (st)
            ST_PRE:  return ST_ROW;
            ST_ROW:  return ST_COL;
            ST_COL:  return ST_CAS;
            ST_CAS:  return ST_TAIL;
            ST_TAIL: return ST_DONE;
            default: return ST_IDLE;
        endcase
    endfunction

    // Length of a phase in ticks, minus one (the value loaded into the down-counter).
    function automatic logic [CNT_W-1:0] phase_span(seq_state_e st, wait_cfg_t c);
        case (st)
            ST_PRE:  return {1'b0, c.rp, 1'b0};
            ST_ROW:  return {1'b0, c.rh, 1'b0};
            ST_CAS:  return {1'b0, c.da, 1'b1};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/dwr_timer.sv
module dwr_timer
    import dram_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R1: an idle counter keeps counting down one step per tick
    p_count_down_r1: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dwr_ctrl.sv
module dwr_ctrl
    import dram_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  wait_cfg_t        cfg_in,
    input  logic             ext_wait,
    input  logic             zero,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output seq_state_e       state
);
    seq_state_e nxt;
    wait_cfg_t  cfg_q;

    assign accept = (state == ST_IDLE) && req;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        if (state == ST_IDLE) begin
            if (req) begin
                nxt      = ST_PRE;
                load     = 1'b1;
                load_val = phase_span(ST_PRE, cfg_in);
            end
        end else if (zero) begin
            if (state == ST_CAS && ext_wait) begin
                // one more bus clock of column strobe
                load     = 1'b1;
                load_val = CNT_W'(1);
            end else begin
                nxt      = next_phase(state);
                load     = 1'b1;
                load_val = phase_span(next_phase(state), cfg_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                cfg_q <= cfg_in;
            end
        end
    end

    // R6: a sampled wait at the end of the column phase keeps the strobe low
    p_wait_extends_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAS && zero && ext_wait) |=> (state == ST_CAS));

    // R11: once past precharge, no new cycle can start before idle
    p_no_reaccept_r11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_PRE) |=> (state != ST_PRE));

endmodule

// File: rtl/dwr_pins.sv
module dwr_pins
    import dram_wr_pkg::*;
#(
    parameter int MA_W   = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [2*MA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  seq_state_e        state,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [MA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done
);
    logic [MA_W-1:0]   row_q;
    logic [MA_W-1:0]   col_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            col_q  <= '0;
            data_q <= '0;
        end else if (accept) begin
            row_q  <= req_addr[2*MA_W-1:MA_W];
            col_q  <= req_addr[MA_W-1:0];
            data_q <= req_data;
        end
    end

    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        done     = 1'b0;
        mem_addr = '0;
        case (state)
            ST_PRE:  begin we_n = 1'b0; mem_addr = row_q; end
            ST_ROW:  begin we_n = 1'b0; ras_n = 1'b0; mem_addr = row_q; end
            ST_COL:  begin we_n = 1'b0; ras_n = 1'b0; mem_addr = col_q; end
            ST_CAS:  begin we_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; mem_addr = col_q; end
            ST_TAIL: begin we_n = 1'b0; ras_n = 1'b0; mem_addr = col_q; end
            ST_DONE: begin we_n = 1'b0; done = 1'b1; mem_addr = col_q; end
            default: ;
        endcase
    end

    assign mem_wdata = data_q;

    // R4: column strobe only inside the row strobe
    p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    // R8: write enable covers the whole column strobe
    p_we_covers_cas_r8: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !we_n);

    // R10: done is a single tick
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: data held while the cycle runs
    p_data_held_r9: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> $stable(mem_wdata));

endmodule

// File: rtl/dram_wr_seq.sv
module dram_wr_seq
    import dram_wr_pkg::*;
#(
    parameter int MA_W   = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [2*MA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        cfg_rp,
    input  logic [1:0]        cfg_rh,
    input  logic [1:0]        cfg_da,
    input  logic              ext_wait,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [MA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done
);
    wait_cfg_t        cfg;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             zero;
    logic             accept;
    seq_state_e       state;

    assign cfg = '{rp: cfg_rp, rh: cfg_rh, da: cfg_da};

    dwr_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .zero     (zero)
    );

    dwr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cfg_in   (cfg),
        .ext_wait (ext_wait),
        .zero     (zero),
        .load     (load),
        .load_val (load_val),
        .accept   (accept),
        .state    (state)
    );

    dwr_pins #(.MA_W(MA_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .state     (state),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done)
    );

    // R12: strobes idle high while in reset
    p_reset_idle_r12: assert property (@(posedge clk)
        $past(rst) |-> (ras_n && cas_n && we_n && !done));

endmodule

// File: tb/sim_dram_wr_seq.sv
`timescale 1ns/1ps
module sim_dram_wr_seq;
    localparam int MA_W   = 10;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [2*MA_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [1:0]        cfg_rp = '0, cfg_rh = '0, cfg_da = '0;
    logic              ext_wait = 1'b1;
    logic              ras_n, cas_n, we_n, done;
    logic [MA_W-1:0]   mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    dram_wr_seq #(.MA_W(MA_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
        .cfg_rp(cfg_rp), .cfg_rh(cfg_rh), .cfg_da(cfg_da), .ext_wait(ext_wait),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 strobes in reset", {ras_n, cas_n, we_n, done}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 strobes after reset", {ras_n, cas_n, we_n, done}, 4'b1110);
    endtask

    task automatic run_cycle(int rp, int rh, int da, int w, bit poke);
        logic [MA_W-1:0]   row, col;
        logic [DATA_W-1:0] dat;
        int t_rf = -1, t_as = -1, t_cf = -1, t_cr = -1, t_rr = -1, t_d = -1;
        int n_done = 0;
        row = MA_W'(10'h155 ^ (rp * 64 + rh * 16 + da * 4 + w));
        col = ~row;
        dat = DATA_W'(16'hA000 + rp * 512 + rh * 128 + da * 32 + w * 8 + int'(poke));
        @(negedge clk);
        req = 1'b1; cfg_rp = 2'(rp); cfg_rh = 2'(rh); cfg_da = 2'(da);
        req_addr = {row, col}; req_data = dat; ext_wait = 1'b1;
        for (int t = 0; t < 150; t++) begin
            @(negedge clk);
            if (t_rf < 0 && !ras_n) t_rf = t;
            if (t_as < 0 && mem_addr == col) t_as = t;
            if (t_cf < 0 && !cas_n) t_cf = t;
            if (t_cf >= 0 && t_cr < 0 && cas_n) t_cr = t;
            if (t_rf >= 0 && t_rr < 0 && ras_n) t_rr = t;
            if (done) begin n_done++; if (t_d < 0) t_d = t; end
            if (t_d < 0 || t == t_d) begin
                chk("R8 we_n low through cycle", int'(we_n), 0);
                chk("R9 data held", int'(mem_wdata == dat), 1);
                chk("R9 address is row or column", int'(mem_addr == row || mem_addr == col), 1);
            end else begin
                chk(poke ? "R11 no second cycle" : "R10 idle after done",
                    int'({ras_n, cas_n, we_n}), 7);
            end
            req = (poke && t == 3);
            if (poke && t == 3) begin
                req_addr = ~{row, col};
                req_data = ~dat;
            end
            if (!cas_n) ext_wait = ((t - t_cf) < (1 + 2 * da + 2 * w));
            else ext_wait = 1'b1;
            if (t_d >= 0 && t >= t_d + 4) break;
        end
        req = 1'b0;
        chk("R2 precharge ticks", t_rf, 1 + 2 * rp);
        chk("R3 row hold ticks", t_as - t_rf, 1 + 2 * rh);
        chk("R4 ras-to-cas ticks", t_cf - t_rf, 2 + 2 * rh);
        chk("R5 column setup ticks", t_cf - t_as, 1);
        chk("R6 cas low ticks", t_cr - t_cf, 2 + 2 * da + 2 * w);
        chk("R7 ras low ticks", t_rr - t_rf, 5 + 2 * rh + 2 * da + 2 * w);
        chk("R1 cycle ticks", t_rr, 6 + 2 * (rp + rh + da + w));
        chk("R8 we lead ok", int'(t_cf >= 2 + 2 * rp + 2 * rh), 1);
        chk("R10 done tick", t_d, t_rr);
        chk("R10 done width", n_done, 1);
    endtask

    task automatic test_sweep();
        for (int rp = 0; rp < 4; rp++)
            for (int rh = 0; rh < 4; rh++)
                for (int da = 0; da < 4; da++)
                    for (int w = 0; w < 4; w++)
                        run_cycle(rp, rh, da, w, 1'b0);
    endtask

    task automatic test_busy_request();
        run_cycle(1, 2, 0, 1, 1'b1);
        run_cycle(0, 0, 0, 0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        test_reset();
        test_sweep();
        test_busy_request();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule